// File: doc/BRIEF.md
# Sequence-Fed Watchdog Timer

This block is a watchdog counter behind a small register bus. Software programs a timeout constant, turns the watchdog on through a control register, and then must keep it alive. It does so by writing a two-byte key to a feed register. The count runs on the input clock divided by a fixed prescaler of four. The counter counts down only after the first complete key that follows enable. Each complete key reloads it from the timeout constant. If the count runs out, the block raises a reset request, provided reset generation is on. It also sets a sticky timeout flag. The flag survives the system reset that follows, so software can read why the chip restarted.

The control state sits in a set of enumerated machines. A register machine holds the constant, the control bits and the flag. A key machine has two states: IDLE, which waits for the first byte, and HALF, which waits for the second. A counting machine has four states. OFF moves to ARMED when enable is set. ARMED moves to RUN on the first complete key. RUN reloads on every later key and moves to EXPIRED on the terminal tick. EXPIRED is held until reset. There are two reset inputs. The power-on reset clears everything. The system reset clears everything except the timeout flag.

Top module: `seq_watchdog`

## Requirements
- R1: After power-on reset, LOAD (address 0) reads 0x000000FF, CTRL (address 1) reads 0, COUNT (address 3) reads 0, and `reset_req` is low.
- R2: CTRL bit 0 is the enable. Writing it as 1 sets it. Once set, a CTRL write with bit 0 equal to 0 leaves it at 1. Only a reset clears it. CTRL bit 1 (reset enable) is freely writable.
- R3: After enable, COUNT stays at 0 and no timeout occurs until the first complete key is written.
- R4: A key is a FEED (address 2) write with low byte 0xAA, followed directly by a FEED write with low byte 0x55. The edge that takes the second write loads COUNT from LOAD.
- R5: Any FEED write other than 0x55 directly after 0xAA aborts the key. This includes a second 0xAA. A 0x55 with no 0xAA before it also has no effect. Neither case reloads COUNT.
- R6: While running, COUNT decreases by one every 4 clock cycles. The timeout falls exactly 4×LOAD cycles after the reloading edge. A LOAD of 0 behaves like 1.
- R7: On timeout, CTRL bit 2 (timeout flag) becomes 1. If CTRL bit 1 is set, `reset_req` goes high in the same cycle. It then stays high until a reset.
- R8: If CTRL bit 1 is clear at timeout, the flag is set but `reset_req` stays low.
- R9: The flag survives `sys_rst_n`, which clears the enable bits and `reset_req`. The flag is cleared by `por_n`, or by a CTRL write with bit 2 equal to 0. Writing bit 2 as 1 does not set it.
- R10: A key that completes on the edge of the terminal tick wins: COUNT reloads and no timeout occurs.
- R11: A key written while the watchdog is disabled is ignored. It neither loads nor starts the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | System reset, active low, keeps the timeout flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 LOAD, 1 CTRL, 2 FEED, 3 COUNT |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational; FEED reads 0) |
| reset_req | output | 1 | Reset request raised on timeout |

## Verification
The completion of a key and the terminal prescaler tick of the last count can land on the same clock edge. The bench loads a small constant and completes a first key. It then times a second key so that its 0x55 write is taken on the edge exactly 4×LOAD cycles later. It judges that COUNT reads LOAD again right after that edge and that `reset_req` stays low. It then checks that the timeout falls a full period after the new reload and not before.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ADDR_LOAD  = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_FEED  = 2'd2,
        ADDR_COUNT = 2'd3
    } wdt_addr_e;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_ARMED,
        WD_RUN,
        WD_EXPIRED
    } wd_state_e;

    typedef enum logic {
        FS_IDLE,
        FS_HALF
    } feed_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_RST_BIT  = 1;
    localparam int CTRL_FLAG_BIT = 2;

endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feed_wr,
    input  logic [7:0] feed_byte,
    output logic       feed_ok
);

    feed_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (feed_wr) begin
            unique case (state_q)
                FS_IDLE: state_d = (feed_byte == KEY_FIRST) ? FS_HALF : FS_IDLE;
                FS_HALF: state_d = FS_IDLE;
                default: state_d = FS_IDLE;
            endcase
        end
    end

    always_comb begin
        feed_ok = 1'b0;
        unique case (state_q)
            FS_IDLE: feed_ok = 1'b0;
            FS_HALF: feed_ok = feed_wr && (feed_byte == KEY_SECOND);
            default: feed_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter logic [DATA_W-1:0] LOAD_RESET = DATA_W'(32'hFF)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout_pulse,
    output logic [DATA_W-1:0] load_val,
    output logic              en,
    output logic              rst_en,
    output logic              flag
);

    logic wr_load;
    logic wr_ctrl;

    always_comb begin
        wr_load = wr_en && (addr == ADDR_LOAD);
        wr_ctrl = wr_en && (addr == ADDR_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_val <= LOAD_RESET;
            en       <= 1'b0;
            rst_en   <= 1'b0;
        end else begin
            if (wr_load) begin
                load_val <= wdata;
            end
            if (wr_ctrl) begin
                rst_en <= wdata[CTRL_RST_BIT];
                if (wdata[CTRL_EN_BIT]) begin
                    en <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag <= 1'b0;
        end else if (timeout_pulse) begin
            flag <= 1'b1;
        end else if (wr_ctrl && !wdata[CTRL_FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rst_en,
    input  logic              feed_ok,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              timeout_pulse,
    output logic              reset_req,
    output logic              live
);

    localparam int               PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

    wd_state_e         state_q, state_d;
    logic [PRE_W-1:0]  pre_q;
    logic              tick;
    logic              reload;
    logic              last_tick;

    always_comb begin
        tick      = (pre_q == PRE_TOP);
        reload    = feed_ok && ((state_q == WD_ARMED) || (state_q == WD_RUN));
        last_tick = (state_q == WD_RUN) && tick && !feed_ok && (count <= DATA_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:     if (en) state_d = WD_ARMED;
            WD_ARMED:   if (feed_ok) state_d = WD_RUN;
            WD_RUN:     if (last_tick) state_d = WD_EXPIRED;
            WD_EXPIRED: state_d = WD_EXPIRED;
            default:    state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (reload) begin
            pre_q <= '0;
            count <= load_val;
        end else if (state_q == WD_RUN) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick && (count != '0)) begin
                count <= count - DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
        end else if (last_tick && rst_en) begin
            reset_req <= 1'b1;
        end
    end

    always_comb begin
        timeout_pulse = last_tick;
        unique case (state_q)
            WD_ARMED, WD_RUN: live = 1'b1;
            default:          live = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
    import wdt_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                PRESCALE   = 4,
    parameter logic [DATA_W-1:0] LOAD_RESET = DATA_W'(32'hFF)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              reset_req
);

    logic              core_rst_n;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] count;
    logic              en;
    logic              rst_en;
    logic              flag;
    logic              feed_ok;
    logic              timeout_pulse;
    logic              live;
    logic              feed_wr;

    assign core_rst_n = por_n & sys_rst_n;
    assign feed_wr    = wr_en && (addr == ADDR_FEED);

    wdt_regs #(
        .DATA_W     (DATA_W),
        .LOAD_RESET (LOAD_RESET)
    ) u_regs (
        .clk           (clk),
        .por_n         (por_n),
        .rst_n         (core_rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .timeout_pulse (timeout_pulse),
        .load_val      (load_val),
        .en            (en),
        .rst_en        (rst_en),
        .flag          (flag)
    );

    wdt_feed_seq u_feed (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .feed_wr   (feed_wr),
        .feed_byte (wdata[7:0]),
        .feed_ok   (feed_ok)
    );

    wdt_core #(
        .DATA_W   (DATA_W),
        .PRESCALE (PRESCALE)
    ) u_core (
        .clk           (clk),
        .rst_n         (core_rst_n),
        .en            (en),
        .rst_en        (rst_en),
        .feed_ok       (feed_ok),
        .load_val      (load_val),
        .count         (count),
        .timeout_pulse (timeout_pulse),
        .reset_req     (reset_req),
        .live          (live)
    );

    always_comb begin
        rdata = '0;
        unique case (wdt_addr_e'(addr))
            ADDR_LOAD:  rdata = load_val;
            ADDR_CTRL: begin
                rdata[CTRL_EN_BIT]   = en;
                rdata[CTRL_RST_BIT]  = rst_en;
                rdata[CTRL_FLAG_BIT] = flag;
            end
            ADDR_FEED:  rdata = '0;
            ADDR_COUNT: rdata = count;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              rst_en,
    input logic              flag,
    input logic              feed_ok,
    input logic              live,
    input logic [DATA_W-1:0] load_val,
    input logic [DATA_W-1:0] count,
    input logic              reset_req
);

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en); // R2

    AST_KEY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_ok && live) |=> (count == $past(load_val))); // R4

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !feed_ok) |=> (count <= $past(count))); // R6

    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> flag); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req); // R7

    AST_REQ_NEEDS_RSTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(rst_en)); // R8

endmodule

bind seq_watchdog wdt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .en        (en),
    .rst_en    (rst_en),
    .flag      (flag),
    .feed_ok   (feed_ok),
    .live      (live),
    .load_val  (load_val),
    .count     (count),
    .reset_req (reset_req)
);

// File: tb/tb_seq_watchdog.sv
module tb_seq_watchdog;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    seq_watchdog dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .reset_req (reset_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish earlier", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    task automatic pulse_sys();
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_por();
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(2'd0, v); check("R1 load", v, 32'hFF);
        rd(2'd1, v); check("R1 ctrl", v, 32'h0);
        rd(2'd3, v); check("R1 count", v, 32'h0);
        check("R1 req", {31'b0, reset_req}, 32'h0);
    endtask

    task automatic t_disabled_key();
        logic [31:0] v;
        wr(2'd0, 32'd5);
        key();
        rd(2'd3, v); check("R11 count while off", v, 32'h0);
        wr(2'd1, 32'h3);
        rd(2'd1, v); check("R2 ctrl set", v, 32'h3);
        idle(30);
        rd(2'd3, v); check("R3 count before key", v, 32'h0);
        check("R3 R11 no req before key", {31'b0, reset_req}, 32'h0);
    endtask

    task automatic t_sticky_enable();
        logic [31:0] v;
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R2 enable sticky", v, 32'h1);
        wr(2'd1, 32'h3);
        rd(2'd1, v); check("R2 rst bit writable", v, 32'h3);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(2'd2, 32'h55);
        rd(2'd3, v); check("R5 lone second byte", v, 32'h0);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
        rd(2'd3, v); check("R5 double first byte", v, 32'h0);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h12);
        wr(2'd2, 32'h55);
        rd(2'd3, v); check("R5 wrong second byte", v, 32'h0);
    endtask

    task automatic t_timeout_reset();
        logic [31:0] v;
        key();
        rd(2'd3, v); check("R4 reload", v, 32'd5);
        idle(4);
        rd(2'd3, v); check("R6 one step", v, 32'd4);
        idle(15);
        check("R6 not early", {31'b0, reset_req}, 32'h0);
        rd(2'd1, v); check("R6 flag not early", v, 32'h3);
        idle(1);
        check("R6 R7 req at 4xLOAD", {31'b0, reset_req}, 32'h1);
        rd(2'd1, v); check("R7 flag set", v, 32'h7);
        rd(2'd3, v); check("R6 count zero", v, 32'h0);
        idle(6);
        check("R7 req held", {31'b0, reset_req}, 32'h1);
    endtask

    task automatic t_sys_reset_flag();
        logic [31:0] v;
        pulse_sys();
        check("R9 req cleared", {31'b0, reset_req}, 32'h0);
        rd(2'd1, v); check("R9 flag survives", v, 32'h4);
        wr(2'd1, 32'h4);
        rd(2'd1, v); check("R9 write one keeps", v, 32'h4);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R9 write zero clears", v, 32'h0);
    endtask

    task automatic t_no_reset_mode();
        logic [31:0] v;
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h1);
        idle(1);
        key();
        idle(8);
        rd(2'd1, v); check("R8 flag without req", v, 32'h5);
        check("R8 req low", {31'b0, reset_req}, 32'h0);
        idle(5);
        check("R8 req stays low", {31'b0, reset_req}, 32'h0);
        pulse_por();
        rd(2'd1, v); check("R9 por clears flag", v, 32'h0);
        rd(2'd0, v); check("R1 load after por", v, 32'hFF);
    endtask

    task automatic t_coincide();
        logic [31:0] v;
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h3);
        idle(1);
        key();
        idle(10);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
        rd(2'd3, v); check("R10 reload wins", v, 32'd3);
        check("R10 no timeout", {31'b0, reset_req}, 32'h0);
        idle(11);
        check("R10 not early after reload", {31'b0, reset_req}, 32'h0);
        idle(1);
        check("R10 timeout after new period", {31'b0, reset_req}, 32'h1);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        sys_rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_disabled_key();
        t_sticky_enable();
        t_abort();
        t_timeout_reset();
        t_sys_reset_flag();
        t_no_reset_mode();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule